// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit-Manipulation Unit

This unit performs the single-operand byte operations selected by the second byte of a prefixed instruction. These are the four rotates (circular and through-carry, in both directions), the three shifts (left arithmetic, right arithmetic, right logical), the nibble swap, and the three single-bit operations (test, clear and set). A separate select input switches the unit to the four one-byte accumulator rotates, which share the rotate datapath but use their own flag rule.

The surrounding core fetches the operand and supplies the current flags. It then takes from the unit the result, a write-back enable, the new flags, a marker saying whether the operand is the memory byte addressed by HL, and the instruction length in machine cycles. The unit performs no memory access itself. Each accepted request is registered, and its outputs appear one clock after the request.

Flags are carried as a 4-bit vector ordered zero (bit 3), subtract (bit 2), half-carry (bit 1) and carry (bit 0).

Top module: `rsb_unit`

## Requirements
- R1: While reset is held, and on the first clock after reset, out_valid, result, wr_en, flags_out, mem_operand and cycles are all zero.
- R2: A request presented with in_valid high at a rising edge appears on the outputs after that edge, with out_valid high for exactly that clock.
- R3: In prefixed mode, op_byte[7:6] picks the group (00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set) and op_byte[2:0] picks the operand (0..7 = B, C, D, E, H, L, memory at HL, A). mem_operand is high only for operand code 6, and it is always low in accumulator-rotate mode.
- R4: In the rotate/shift group, op_byte[5:3] values 0, 1, 2 and 3 give rotate-left-circular, rotate-right-circular, rotate-left-through-carry and rotate-right-through-carry. Carry receives the bit rotated out, zero is set when the result is 0, and subtract and half-carry are cleared.
- R5: op_byte[5:3] = 4 shifts left and brings 0 into bit 0. A value of 5 shifts right and keeps bit 7. A value of 7 shifts right and brings 0 into bit 7. In all three, carry receives the bit shifted out, zero follows the result, and subtract and half-carry are cleared.
- R6: op_byte[5:3] = 6 exchanges the high and low nibbles, sets zero from the result, and clears subtract, half-carry and carry.
- R7: Bit test (group 01) examines operand bit op_byte[5:3]. Zero is set when that bit is 0, subtract is cleared, half-carry is set, carry is unchanged, the result equals the operand, and wr_en is low.
- R8: Bit clear and bit set (groups 10 and 11) force operand bit op_byte[5:3] to 0 or 1, leave every other bit unchanged, and return flags_out equal to flags_in.
- R9: In accumulator-rotate mode (short_rot high), op_byte[4:3] values 0, 1, 2 and 3 give rotate-left-circular, rotate-right-circular, rotate-left-through-carry and rotate-right-through-carry. Zero, subtract and half-carry are always cleared, even for a zero result, and carry receives the bit rotated out.
- R10: cycles is 2 for a register operand and 4 for a memory operand. The exception is bit test on a memory operand, which gives 3. Accumulator rotates give 1.
- R11: wr_en is high for every operation except bit test.
- R12: A clock with in_valid low drops out_valid and leaves result, wr_en, flags_out, mem_operand and cycles unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this clock |
| short_rot | input | 1 | High selects the one-byte accumulator rotates |
| op_byte | input | 8 | Prefixed second byte, or the accumulator-rotate opcode |
| operand | input | OPW | Operand value fetched by the core |
| flags_in | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| out_valid | output | 1 | Result registered this clock |
| result | output | OPW | Value to write back |
| wr_en | output | 1 | Result must be written back |
| flags_out | output | 4 | New flags {zero, subtract, half-carry, carry} |
| mem_operand | output | 1 | Operand is the memory byte at HL |
| cycles | output | CYC_W | Instruction length in machine cycles |

## Verification
The bench builds the unit with its default parameters: an 8-bit operand and cycle counts of 2, 4, 3 and 1. With these values the whole prefixed opcode space can be swept. The bench applies all 256 second-byte values, each against eight operand patterns (all-zero, all-one, single end bits and alternating nibbles) with carry both clear and set. This covers every operation, every bit index and every operand code, including the memory case. All four accumulator rotates are then swept over every operand value with both carry settings, so the always-clear zero rule is exercised on zero results, and idle clocks check that the outputs hold.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SK_RLC  = 3'd0,
        SK_RRC  = 3'd1,
        SK_RL   = 3'd2,
        SK_RR   = 3'd3,
        SK_SLA  = 3'd4,
        SK_SRA  = 3'd5,
        SK_SWAP = 3'd6,
        SK_SRL  = 3'd7
    } kind_e;

    localparam logic [2:0] OPND_MEM = 3'd6;
    localparam logic [2:0] OPND_ACC = 3'd7;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic       short_op;
        grp_e       grp;
        kind_e      kind;
        logic [2:0] idx;
        logic [2:0] opnd;
        logic       is_mem;
    } dec_t;

endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
    import rsb_pkg::*;
(
    input  logic       short_rot,
    input  logic [7:0] op_byte,
    output dec_t       dec_o
);

    always_comb begin
        dec_o = '0;
        if (short_rot) begin
            // accumulator rotates: only bits 4:3 carry meaning
            dec_o.short_op = 1'b1;
            dec_o.grp      = GRP_SHIFT;
            dec_o.kind     = kind_e'({1'b0, op_byte[4:3]});
            dec_o.idx      = 3'd0;
            dec_o.opnd     = OPND_ACC;
            dec_o.is_mem   = 1'b0;
        end else begin
            dec_o.short_op = 1'b0;
            dec_o.grp      = grp_e'(op_byte[7:6]);
            dec_o.kind     = kind_e'(op_byte[5:3]);
            dec_o.idx      = op_byte[5:3];
            dec_o.opnd     = op_byte[2:0];
            dec_o.is_mem   = (op_byte[2:0] == OPND_MEM);
        end
    end

endmodule

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
#(
    parameter int OPW = 8,
    localparam int HALF = OPW / 2
) (
    input  logic [OPW-1:0] x_i,
    input  kind_e          kind_i,
    input  logic           cin_i,
    output logic [OPW-1:0] res_o,
    output logic           cout_o
);

    always_comb begin
        res_o  = x_i;
        cout_o = 1'b0;
        case (kind_i)
            SK_RLC: begin
                res_o  = {x_i[OPW-2:0], x_i[OPW-1]};
                cout_o = x_i[OPW-1];
            end
            SK_RRC: begin
                res_o  = {x_i[0], x_i[OPW-1:1]};
                cout_o = x_i[0];
            end
            SK_RL: begin
                res_o  = {x_i[OPW-2:0], cin_i};
                cout_o = x_i[OPW-1];
            end
            SK_RR: begin
                res_o  = {cin_i, x_i[OPW-1:1]};
                cout_o = x_i[0];
            end
            SK_SLA: begin
                res_o  = {x_i[OPW-2:0], 1'b0};
                cout_o = x_i[OPW-1];
            end
            SK_SRA: begin
                res_o  = {x_i[OPW-1], x_i[OPW-1:1]};
                cout_o = x_i[0];
            end
            SK_SWAP: begin
                res_o  = {x_i[HALF-1:0], x_i[OPW-1:HALF]};
                cout_o = 1'b0;
            end
            SK_SRL: begin
                res_o  = {1'b0, x_i[OPW-1:1]};
                cout_o = x_i[0];
            end
            default: begin
                res_o  = x_i;
                cout_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] x_i,
    input  logic [2:0]     idx_i,
    input  grp_e           grp_i,
    output logic [OPW-1:0] res_o,
    output logic           bit_o
);

    logic [OPW-1:0] hit;
    logic           force_en;
    logic           force_val;

    assign force_en  = (grp_i == GRP_CLR) || (grp_i == GRP_SET);
    assign force_val = (grp_i == GRP_SET);

    for (genvar gi = 0; gi < OPW; gi++) begin : g_bit
        assign hit[gi]   = (idx_i == 3'(gi));
        assign res_o[gi] = (hit[gi] && force_en) ? force_val : x_i[gi];
    end

    assign bit_o = |(x_i & hit);

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int OPW          = 8,
    parameter int REG_CYC      = 2,
    parameter int MEM_CYC      = 4,
    parameter int MEM_TEST_CYC = 3,
    parameter int SHORT_CYC    = 1,
    localparam int CYC_W       = $clog2(MEM_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             short_rot,
    input  logic [7:0]       op_byte,
    input  logic [OPW-1:0]   operand,
    input  logic [3:0]       flags_in,
    output logic             out_valid,
    output logic [OPW-1:0]   result,
    output logic             wr_en,
    output logic [3:0]       flags_out,
    output logic             mem_operand,
    output logic [CYC_W-1:0] cycles
);

    typedef struct packed {
        logic             valid;
        logic [OPW-1:0]   res;
        logic             wr;
        flags_t           fl;
        logic             mem;
        logic [CYC_W-1:0] cyc;
    } out_t;

    dec_t           dec;
    flags_t         fin;
    logic [OPW-1:0] sh_res;
    logic           sh_cout;
    logic [OPW-1:0] bo_res;
    logic           bo_bit;
    out_t           out_d;
    out_t           out_q;

    assign fin = flags_t'(flags_in);

    rsb_decode u_dec (
        .short_rot (short_rot),
        .op_byte   (op_byte),
        .dec_o     (dec)
    );

    rsb_shifter #(.OPW(OPW)) u_sh (
        .x_i    (operand),
        .kind_i (dec.kind),
        .cin_i  (fin.c),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    rsb_bitop #(.OPW(OPW)) u_bo (
        .x_i   (operand),
        .idx_i (dec.idx),
        .grp_i (dec.grp),
        .res_o (bo_res),
        .bit_o (bo_bit)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (in_valid) begin
            out_d.valid = 1'b1;
            out_d.mem   = dec.is_mem;
            case (dec.grp)
                GRP_SHIFT: begin
                    out_d.res  = sh_res;
                    out_d.wr   = 1'b1;
                    out_d.fl.z = dec.short_op ? 1'b0 : (sh_res == '0);
                    out_d.fl.n = 1'b0;
                    out_d.fl.h = 1'b0;
                    out_d.fl.c = sh_cout;
                end
                GRP_TEST: begin
                    out_d.res  = operand;
                    out_d.wr   = 1'b0;
                    out_d.fl.z = ~bo_bit;
                    out_d.fl.n = 1'b0;
                    out_d.fl.h = 1'b1;
                    out_d.fl.c = fin.c;
                end
                default: begin
                    out_d.res = bo_res;
                    out_d.wr  = 1'b1;
                    out_d.fl  = fin;
                end
            endcase
            if (dec.short_op) begin
                out_d.cyc = CYC_W'(SHORT_CYC);
            end else if (dec.is_mem) begin
                out_d.cyc = (dec.grp == GRP_TEST) ? CYC_W'(MEM_TEST_CYC) : CYC_W'(MEM_CYC);
            end else begin
                out_d.cyc = CYC_W'(REG_CYC);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid   = out_q.valid;
    assign result      = out_q.res;
    assign wr_en       = out_q.wr;
    assign flags_out   = out_q.fl;
    assign mem_operand = out_q.mem;
    assign cycles      = out_q.cyc;

endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
    parameter int OPW          = 8,
    parameter int CYC_W        = 3,
    parameter int MEM_TEST_CYC = 3,
    parameter int SHORT_CYC    = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             short_rot,
    input logic [7:0]       op_byte,
    input logic [OPW-1:0]   operand,
    input logic [3:0]       flags_in,
    input logic             out_valid,
    input logic [OPW-1:0]   result,
    input logic             wr_en,
    input logic [3:0]       flags_out,
    input logic             mem_operand,
    input logic [CYC_W-1:0] cycles
);

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_MEM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !short_rot) |=> (mem_operand == ($past(op_byte[2:0]) == 3'd6))); // R3

    AST_TEST_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !short_rot && op_byte[7:6] == 2'b01) |=> (!wr_en && result == $past(operand))); // R7

    AST_TEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !short_rot && op_byte[7:6] == 2'b01) |=>
            (flags_out[2:1] == 2'b01 && flags_out[0] == $past(flags_in[0]))); // R7

    AST_TEST_MEMCYC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !short_rot && op_byte[7:6] == 2'b01 && op_byte[2:0] == 3'd6) |=>
            (cycles == CYC_W'(MEM_TEST_CYC))); // R10

    AST_SETCLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !short_rot && op_byte[7]) |=> (flags_out == $past(flags_in) && wr_en)); // R8

    AST_SHORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && short_rot) |=> (flags_out[3:1] == 3'b000 && !mem_operand)); // R9

    AST_SHORT_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && short_rot) |=> (cycles == CYC_W'(SHORT_CYC) && wr_en)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out) && $stable(cycles))); // R12

endmodule

bind rsb_unit rsb_unit_chk #(
    .OPW          (OPW),
    .CYC_W        (CYC_W),
    .MEM_TEST_CYC (MEM_TEST_CYC),
    .SHORT_CYC    (SHORT_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .short_rot   (short_rot),
    .op_byte     (op_byte),
    .operand     (operand),
    .flags_in    (flags_in),
    .out_valid   (out_valid),
    .result      (result),
    .wr_en       (wr_en),
    .flags_out   (flags_out),
    .mem_operand (mem_operand),
    .cycles      (cycles)
);

// File: tb/rsb_unit_tb.sv
`timescale 1ns/1ps
module rsb_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       short_rot = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic [7:0] operand = 8'h00;
    logic [3:0] flags_in = 4'h0;
    logic       out_valid;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags_out;
    logic       mem_operand;
    logic [2:0] cycles;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rsb_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .short_rot   (short_rot),
        .op_byte     (op_byte),
        .operand     (operand),
        .flags_in    (flags_in),
        .out_valid   (out_valid),
        .result      (result),
        .wr_en       (wr_en),
        .flags_out   (flags_out),
        .mem_operand (mem_operand),
        .cycles      (cycles)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (op=%02h x=%02h f=%01h short=%0d)",
                     req, what, act, exp, op_byte, operand, flags_in, short_rot);
        end
    endtask

    // reference model built from the requirements with plain arithmetic
    task automatic model(input logic s, input logic [7:0] op, input logic [7:0] x,
                         input logic [3:0] fl, output int r, output int f, output int w,
                         output int m, output int cy, output string tag);
        int xi = int'(x);
        int ci = int'(fl[0]);
        int grp = s ? 0 : int'(op) / 64;
        int k = s ? (int'(op) / 8) % 4 : (int'(op) / 8) % 8;
        int co = 0;
        int zb;
        int b;
        m = (!s && (int'(op) % 8) == 6) ? 1 : 0;
        w = 1;
        if (grp == 0) begin
            case (k)
                0: begin r = (xi * 2) % 256 + xi / 128;  co = xi / 128; tag = "R4"; end
                1: begin r = xi / 2 + (xi % 2) * 128;    co = xi % 2;   tag = "R4"; end
                2: begin r = (xi * 2) % 256 + ci;        co = xi / 128; tag = "R4"; end
                3: begin r = xi / 2 + ci * 128;          co = xi % 2;   tag = "R4"; end
                4: begin r = (xi * 2) % 256;             co = xi / 128; tag = "R5"; end
                5: begin r = xi / 2 + (xi / 128) * 128;  co = xi % 2;   tag = "R5"; end
                6: begin r = (xi % 16) * 16 + xi / 16;   co = 0;        tag = "R6"; end
                default: begin r = xi / 2;               co = xi % 2;   tag = "R5"; end
            endcase
            if (s) tag = "R9";
            zb = (!s && r == 0) ? 1 : 0;
            f = zb * 8 + co;
        end else begin
            b = (xi / (1 << k)) % 2;
            if (grp == 1) begin
                r = xi; w = 0; tag = "R7";
                f = (b == 0 ? 8 : 0) + 2 + ci;
            end else begin
                tag = "R8";
                f = int'(fl);
                if (grp == 2) r = xi - b * (1 << k);
                else          r = xi + (1 - b) * (1 << k);
            end
        end
        if (s)      cy = 1;
        else if (m == 1) cy = (grp == 1) ? 3 : 4;
        else        cy = 2;
    endtask

    // drive at a falling edge, observe at the next falling edge
    task automatic run_vec(input logic s, input logic [7:0] op, input logic [7:0] x, input logic [3:0] fl);
        int er, ef, ew, em, ec;
        string tag;
        model(s, op, x, fl, er, ef, ew, em, ec, tag);
        in_valid  = 1'b1;
        short_rot = s;
        op_byte   = op;
        operand   = x;
        flags_in  = fl;
        @(negedge clk);
        check("R2", "out_valid", int'(out_valid), 1);
        check(tag, "result", int'(result), er);
        check(tag, "flags", int'(flags_out), ef);
        check("R11", "wr_en", int'(wr_en), ew);
        check("R3", "mem_operand", int'(mem_operand), em);
        check("R10", "cycles", int'(cycles), ec);
    endtask

    task automatic idle_check();
        logic [7:0] r0 = result;
        logic [3:0] f0 = flags_out;
        logic       w0 = wr_en;
        logic       m0 = mem_operand;
        logic [2:0] c0 = cycles;
        in_valid  = 1'b0;
        short_rot = ~short_rot;
        op_byte   = ~op_byte;
        operand   = ~operand;
        flags_in  = ~flags_in;
        @(negedge clk);
        check("R12", "out_valid idle", int'(out_valid), 0);
        check("R12", "result held", int'(result), int'(r0));
        check("R12", "flags held", int'(flags_out), int'(f0));
        check("R12", "wr_en held", int'(wr_en), int'(w0));
        check("R12", "mem held", int'(mem_operand), int'(m0));
        check("R12", "cycles held", int'(cycles), int'(c0));
    endtask

    localparam logic [7:0] PATS [8] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A, 8'hA5, 8'h0F, 8'h3C};

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        // R1: outputs zero under reset
        check("R1", "out_valid reset", int'(out_valid), 0);
        check("R1", "result reset", int'(result), 0);
        check("R1", "flags reset", int'(flags_out), 0);
        check("R1", "wr_en reset", int'(wr_en), 0);
        check("R1", "mem reset", int'(mem_operand), 0);
        check("R1", "cycles reset", int'(cycles), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "result after reset", int'(result), 0);

        // prefixed sweep: every second byte, eight operand patterns, both carries
        for (int op = 0; op < 256; op++) begin
            for (int p = 0; p < 8; p++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [3:0] fl;
                    fl = {PATS[p][0], PATS[p][1] ^ op[0], op[1], c[0]};
                    run_vec(1'b0, 8'(op), PATS[p], fl);
                end
            end
            if (op % 32 == 31) idle_check();
        end

        // accumulator rotates: every operand, both carries (R9)
        for (int k = 0; k < 4; k++) begin
            for (int x = 0; x < 256; x++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] opc;
                    opc = 8'h07 | 8'(k * 8);
                    run_vec(1'b1, opc, 8'(x), {3'b111, c[0]});
                end
            end
            idle_check();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule